// File: doc/BRIEF.md
# Key-protected watchdog interval timer

This block is a watchdog peripheral built around an 8-bit up-counter and an 8-bit control/status register, both reached over a small register bus that carries byte and 16-bit word accesses. The counter advances once per tick of a prescaler whose divide ratio, a power of two from 2 to 256, comes from a 3-bit clock select field. When the counter wraps from 0xFF to 0x00, the block does one of two things. In watchdog mode it sets a watchdog overflow flag and issues a one-clock reset request, together with a reset-type level. In interval mode it sets an interval overflow flag and holds an interrupt request high.

Stray writes cannot disturb the block. A register changes only on a word write whose upper byte carries that register's own key: 0x5A for the counter and 0xA5 for the control register. Every other write is dropped without any sign. Both registers are read with byte accesses. The control register keeps its contents through the reset that the block itself requests. Only the power-on reset input clears it.

A small state machine tracks the timer. It has three states. ST_STOP means the timer is disabled and the count is held. ST_RUN means the timer is counting. ST_PULSE lasts one clock and is the cycle in which the reset request is driven. Its transitions are:

- ST_STOP to ST_RUN when the enable bit becomes 1.
- ST_RUN to ST_STOP when the enable bit becomes 0.
- ST_RUN to ST_PULSE on an overflow in watchdog mode.
- ST_PULSE to ST_RUN when the enable bit is 1 after the pulse.
- ST_PULSE to ST_STOP when the enable bit is 0 after the pulse.

Top module: `wdt_keyed`

## Requirements
- R1: While `por_n` is low and right after it goes high, byte reads of both registers return 0x00, and `rst_req` and `irq` are 0.
- R2: A byte read (`bus_word`=0) with `bus_addr`=0 returns the count. With `bus_addr`=1 it returns the control register, laid out as bit7 enable, bit6 mode (1 = watchdog, 0 = interval), bit5 reset type, bit4 watchdog flag, bit3 interval flag, bits2..0 clock select. A word read returns 0x00.
- R3: A word write to `bus_addr`=0 with upper byte 0x5A loads the low byte into the counter at that clock edge and restarts the prescaler.
- R4: A word write to `bus_addr`=1 with upper byte 0xA5 loads bits 7,6,5 and 2..0 from the low byte. A 0 written to bit 4 or bit 3 clears that flag, and a 1 written to either leaves it unchanged.
- R5: A byte write, a word write with any other upper byte, or a word write carrying the other register's key changes neither register.
- R6: With the enable bit at 0 the count holds its value.
- R7: With the enable bit at 1 and clock select k, the count increases by one every 2^(k+1) clocks. The first step comes 2^(k+1) clocks after an accepted counter write.
- R8: In watchdog mode the 0xFF to 0x00 step sets bit 4 and drives `rst_req` high for exactly one clock, starting right after that edge. During that clock `rst_type` equals bit 5.
- R9: In interval mode the 0xFF to 0x00 step sets bit 3, `irq` is high while bit 3 is set and the mode is interval, and `rst_req` stays 0.
- R10: After a watchdog overflow the control register keeps its enable, mode, reset type and clock select bits, and the counter keeps counting from 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| bus_addr | input | 1 | 0 = counter, 1 = control/status register |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 8 | Byte read data, 0x00 when no byte read is active |
| rst_req | output | 1 | One-clock reset request on watchdog overflow |
| rst_type | output | 1 | Reset type selected by control bit 5 |
| irq | output | 1 | Interval interrupt request, level |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 3-bit clock select and thus an 8-bit prescaler, and the keys 0x5A and 0xA5. Because a keyed write can preload the counter close to 0xFF, overflow is only a few ticks away at every clock select value, up to the /256 ratio. This lets the random trials cover all eight divide ratios, both modes and both sides of the wrap. Directed cases then pin the exact clock of the reset pulse, the interrupt level and its clearing, and each kind of rejected write.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int CKS_W    = 3;
    localparam int REG_W    = 8;
    localparam logic ADDR_CNT = 1'b0;
    localparam logic ADDR_CSR = 1'b1;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic             tme;
        logic             wt;
        logic             rsts;
        logic             wovf;
        logic             iovf;
        logic [CKS_W-1:0] cks;
    } wdt_csr_t;
endpackage

// File: rtl/wdt_keydec.sv
`timescale 1ns/1ps
module wdt_keydec #(
    parameter int          KW      = 8,
    parameter logic [KW-1:0] KEY_CNT = 8'h5A,
    parameter logic [KW-1:0] KEY_CSR = 8'hA5
) (
    input  logic          sel,
    input  logic          wr,
    input  logic          word,
    input  logic          addr,
    input  logic [KW-1:0] key,
    output logic          cnt_we,
    output logic          csr_we,
    output logic          bad_wr
);
    import wdt_pkg::*;

    logic word_wr;

    always_comb begin
        word_wr = sel && wr && word;
        cnt_we  = word_wr && (addr == ADDR_CNT) && (key == KEY_CNT);
        csr_we  = word_wr && (addr == ADDR_CSR) && (key == KEY_CSR);
        bad_wr  = sel && wr && !cnt_we && !csr_we;
    end
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SEL_W-1:0] cks,
    output logic             tick
);
    localparam int PRE_W = 2 ** SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] tap;

    genvar gi;
    generate
        for (gi = 0; gi < PRE_W; gi++) begin : g_tap
            assign tap[gi] = &pre_q[gi:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (en)
            pre_q <= pre_q + 1'b1;
    end

    assign tick = en && !clr && tap[cks];

    // R3: an accepted counter write restarts the divider from zero
    p_pre_restart_r3: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         en,
    input  logic         tick,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (we)
            cnt_q <= wdata;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
    assign ovf = tick && !we && (&cnt_q);

    // R6: disabled timer holds the count
    p_hold_when_stopped_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !we) |=> $stable(cnt_q));

    // R7: each prescaler tick adds exactly one
    p_step_on_tick_r7: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !we) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: an accepted write loads the low byte
    p_load_r3: assert property (@(posedge clk) disable iff (!por_n)
        we |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl (
    input  logic                           clk,
    input  logic                           por_n,
    input  logic                           csr_we,
    input  logic [wdt_pkg::REG_W-1:0]      wdata,
    input  logic                           ovf,
    output wdt_pkg::wdt_csr_t              csr,
    output logic                           en,
    output logic                           rst_req
);
    import wdt_pkg::*;

    wdt_csr_t   csr_q;
    wdt_csr_t   csr_d;
    wdt_csr_t   wr_val;
    wdt_state_e state_q;
    wdt_state_e state_d;
    logic       set_w;
    logic       set_i;

    // register next value: keyed write, then overflow flag set
    always_comb begin
        wr_val = wdt_csr_t'(wdata);
        set_w  = ovf && csr_q.wt;
        set_i  = ovf && !csr_q.wt;
        csr_d  = csr_q;
        if (csr_we) begin
            csr_d.tme  = wr_val.tme;
            csr_d.wt   = wr_val.wt;
            csr_d.rsts = wr_val.rsts;
            csr_d.cks  = wr_val.cks;
            csr_d.wovf = csr_q.wovf && wr_val.wovf;
            csr_d.iovf = csr_q.iovf && wr_val.iovf;
        end
        csr_d.wovf = csr_d.wovf || set_w;
        csr_d.iovf = csr_d.iovf || set_i;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            csr_q <= '0;
        else
            csr_q <= csr_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  state_d = csr_d.tme ? ST_RUN : ST_STOP;
            ST_RUN: begin
                if (set_w)
                    state_d = ST_PULSE;
                else
                    state_d = csr_d.tme ? ST_RUN : ST_STOP;
            end
            ST_PULSE: state_d = csr_d.tme ? ST_RUN : ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= ST_STOP;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        rst_req = 1'b0;
        en      = 1'b0;
        unique case (state_q)
            ST_STOP:  begin rst_req = 1'b0; en = 1'b0;      end
            ST_RUN:   begin rst_req = 1'b0; en = csr_q.tme; end
            ST_PULSE: begin rst_req = 1'b1; en = csr_q.tme; end
            default:  begin rst_req = 1'b0; en = 1'b0;      end
        endcase
    end

    assign csr = csr_q;

    // R8: reset request lasts one clock
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R8: watchdog flag rises only from a watchdog-mode overflow
    p_wovf_source_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(csr_q.wovf) |-> $past(ovf && csr_q.wt));

    // R9: interval overflow never requests a reset
    p_no_reset_interval_r9: assert property (@(posedge clk) disable iff (!por_n)
        (ovf && !csr_q.wt) |=> !rst_req);

    // R4: a flag can only be cleared by a keyed write
    p_flag_clear_keyed_r4: assert property (@(posedge clk) disable iff (!por_n)
        $fell(csr_q.iovf) |-> $past(csr_we));

    // R10: own overflow keeps configuration bits
    p_cfg_kept_r10: assert property (@(posedge clk) disable iff (!por_n)
        (ovf && !csr_we) |=> (csr_q.tme == $past(csr_q.tme)) &&
                             (csr_q.cks == $past(csr_q.cks)) &&
                             (csr_q.rsts == $past(csr_q.rsts)));
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed #(
    parameter int          CW      = 8,
    parameter logic [7:0]  KEY_CNT = 8'h5A,
    parameter logic [7:0]  KEY_CSR = 8'hA5
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        rst_req,
    output logic        rst_type,
    output logic        irq
);
    import wdt_pkg::*;

    logic             cnt_we;
    logic             csr_we;
    logic             bad_wr;
    logic             en;
    logic             tick;
    logic             ovf;
    logic [CW-1:0]    cnt;
    wdt_csr_t         csr;

    wdt_keydec #(.KW(8), .KEY_CNT(KEY_CNT), .KEY_CSR(KEY_CSR)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .word   (bus_word),
        .addr   (bus_addr),
        .key    (bus_wdata[15:8]),
        .cnt_we (cnt_we),
        .csr_we (csr_we),
        .bad_wr (bad_wr)
    );

    wdt_prescaler #(.SEL_W(CKS_W)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .en    (en),
        .clr   (cnt_we),
        .cks   (csr.cks),
        .tick  (tick)
    );

    wdt_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .en    (en),
        .tick  (tick),
        .we    (cnt_we),
        .wdata (bus_wdata[CW-1:0]),
        .cnt   (cnt),
        .ovf   (ovf)
    );

    wdt_ctrl u_ctrl (
        .clk     (clk),
        .por_n   (por_n),
        .csr_we  (csr_we),
        .wdata   (bus_wdata[REG_W-1:0]),
        .ovf     (ovf),
        .csr     (csr),
        .en      (en),
        .rst_req (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && !bus_word)
            bus_rdata = (bus_addr == ADDR_CNT) ? 8'(cnt) : csr;
    end

    assign rst_type = csr.rsts;
    assign irq      = csr.iovf && !csr.wt;

    // R5: rejected writes leave the control register alone
    p_bad_write_csr_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bad_wr && !ovf) |=> $stable(csr));

    // R5: rejected writes leave the counter alone
    p_bad_write_cnt_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bad_wr && !tick) |=> $stable(cnt));

    // R9: interrupt appears only after an overflow or a control write
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq) |-> $past(ovf || csr_we));
endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rst_req;
    logic        rst_type;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    wdt_keyed uut (
        .clk       (clk),
        .por_n     (por_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .rst_type  (rst_type),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog R0: got %0d cycles, expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_count(input logic [7:0] v, input int m);
        return 8'((int'(v) + m) % 256);
    endfunction

    function automatic logic [7:0] exp_csr(input logic tme, input logic wt, input logic rs,
                                           input logic wf, input logic itf, input logic [2:0] k);
        return {tme, wt, rs, wf, itf, k};
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_tests = n_tests + 1;
        if (got != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic word, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic a, input logic word, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_word = 1'b0;
        #1;
    endtask

    task automatic wait_clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        bus_read(1'b0, 1'b0, rd); check("R1", "count in reset", rd, 0);
        bus_read(1'b1, 1'b0, rd); check("R1", "csr in reset", rd, 0);
        por_n = 1'b1;
        bus_read(1'b0, 1'b0, rd); check("R1", "count after reset", rd, 0);
        bus_read(1'b1, 1'b0, rd); check("R1", "csr after reset", rd, 0);
        check("R1", "rst_req after reset", rst_req, 0);
        check("R1", "irq after reset", irq, 0);

        // keyed loads while stopped
        bus_write(1'b0, 1'b1, 16'h5A33);
        bus_read(1'b0, 1'b0, rd); check("R3", "counter load", rd, 8'h33);
        bus_read(1'b0, 1'b1, rd); check("R2", "word read returns zero", rd, 0);
        bus_write(1'b1, 1'b1, 16'hA527);
        bus_read(1'b1, 1'b0, rd); check("R4", "csr load while disabled", rd, 8'h27);

        // rejected writes
        bus_write(1'b0, 1'b0, 16'h5A77);
        bus_write(1'b0, 1'b1, 16'hA577);
        bus_write(1'b0, 1'b1, 16'h5B77);
        bus_read(1'b0, 1'b0, rd); check("R5", "counter after bad writes", rd, 8'h33);
        bus_write(1'b1, 1'b0, 16'hA587);
        bus_write(1'b1, 1'b1, 16'h5A87);
        bus_write(1'b1, 1'b1, 16'h0087);
        bus_read(1'b1, 1'b0, rd); check("R5", "csr after bad writes", rd, 8'h27);

        // stopped timer holds
        wait_clocks(50);
        bus_read(1'b0, 1'b0, rd); check("R6", "count held when disabled", rd, 8'h33);

        // writing 1 to flags has no effect
        bus_write(1'b0, 1'b1, 16'h5A00);
        bus_write(1'b1, 1'b1, 16'hA598);
        bus_read(1'b1, 1'b0, rd); check("R4", "flag write of 1 ignored", rd, 8'h80);

        // watchdog overflow, divide by 2
        bus_write(1'b1, 1'b1, 16'hA5E0);
        bus_write(1'b0, 1'b1, 16'h5AFF);
        wait_clocks(1);
        check("R8", "no pulse before overflow", rst_req, 0);
        wait_clocks(1);
        check("R8", "reset pulse high", rst_req, 1);
        check("R8", "reset type during pulse", rst_type, 1);
        bus_read(1'b0, 1'b0, rd); check("R8", "count wrapped", rd, 0);
        bus_read(1'b1, 1'b0, rd); check("R10", "csr kept with flag", rd, 8'hF0);
        check("R8", "no irq in watchdog mode", irq, 0);
        wait_clocks(1);
        check("R8", "reset pulse one clock", rst_req, 0);
        wait_clocks(1);
        bus_read(1'b0, 1'b0, rd); check("R10", "count continues", rd, 8'h01);
        bus_write(1'b1, 1'b1, 16'hA5E0);
        bus_read(1'b1, 1'b0, rd); check("R4", "watchdog flag cleared", rd, 8'hE0);

        // interval overflow, divide by 2
        bus_write(1'b1, 1'b1, 16'hA580);
        bus_write(1'b0, 1'b1, 16'h5AFF);
        wait_clocks(2);
        check("R9", "irq raised", irq, 1);
        check("R9", "no reset in interval mode", rst_req, 0);
        bus_read(1'b1, 1'b0, rd); check("R9", "interval flag set", rd, 8'h88);
        wait_clocks(5);
        check("R9", "irq is a level", irq, 1);
        bus_write(1'b1, 1'b1, 16'hA580);
        check("R9", "irq cleared with flag", irq, 0);

        // random trials over divide ratios and modes
        for (int t = 0; t < 40; t++) begin
            logic [2:0] k;
            logic       wt;
            logic       rs;
            logic [7:0] v;
            int         m;
            int         n;
            logic       wrapped;
            k  = 3'($urandom % 8);
            wt = 1'($urandom % 2);
            rs = 1'($urandom % 2);
            v  = (t % 4 == 0) ? 8'hFE : 8'($urandom % 256);
            m  = 1 + int'($urandom % 3);
            n  = 1 << (int'(k) + 1);
            wrapped = (int'(v) + m) > 255;
            bus_write(1'b0, 1'b1, 16'h5A00);
            bus_write(1'b1, 1'b1, {8'hA5, exp_csr(1'b1, wt, rs, 1'b0, 1'b0, k)});
            bus_write(1'b0, 1'b1, {8'h5A, v});
            wait_clocks(n * m - 1);
            bus_read(1'b0, 1'b0, rd);
            check("R7", "count one clock before step", rd, exp_count(v, m - 1));
            wait_clocks(1);
            bus_read(1'b0, 1'b0, rd);
            check("R7", "count after ticks", rd, exp_count(v, m));
            bus_read(1'b1, 1'b0, rd);
            check("R4", "csr with flags",
                  rd, exp_csr(1'b1, wt, rs, wrapped && wt, wrapped && !wt, k));
            check("R9", "irq level", irq, wrapped && !wt);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule